// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This unit collects one-cycle interrupt event pulses into a 32-bit sticky status register. A mask register gates the status, and the gated result drives a single active-low interrupt line toward a host. The host sees the unit as two byte-addressed registers on a simple bus with address, lane, read strobe and write strobe. Read data comes back one cycle after the strobe.

The host reads the status one lane at a time, starting at the lowest lane and ending at the highest. The lowest-lane read takes a snapshot of the status. The highest-lane read then clears only the bits held in that snapshot. An event that arrives between the two reads therefore stays pending. A clearing read also holds the interrupt line inactive for a fixed number of cycles. This gives the host a clean edge if sources are still pending.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status is all zero, the mask is all zero, `irq_n` is 1 and `rd_data` is 0.
- R2: A 1 on bit i of `evt` in one cycle sets status bit i at the next clock edge. The bit stays set until a clearing read removes it.
- R3: A read of address 0 (status) at lane k returns status bits [8k+7:8k] on `rd_data`, registered one cycle after the strobe. Lane 0 holds bits 7:0 and lane 3 holds bits 31:24. A read of address 1 returns the same lane of the mask. Any other address returns 0.
- R4: A status read at lane 0 captures a snapshot of the status. A later status read at lane 3 clears exactly the bits set in that snapshot and ends the sequence.
- R5: Status bits raised after the lane-0 read are still set after the lane-3 read.
- R6: A lane-3 status read with no lane-0 read since the last clearing read clears nothing.
- R7: If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R8: Outside the forced window, `irq_n` is 0 one cycle after any status bit and its mask bit are both 1, and 1 otherwise.
- R9: A clearing lane-3 read forces `irq_n` to 1 for the two clock cycles that follow it, even if masked bits remain pending.
- R10: A write to address 1 at lane k loads `wr_data` into mask bits [8k+7:8k]. A 1 enables the matching status bit. Writes to any other address have no effect.
- R11: With the mask at its reset value, events set status bits but `irq_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | 32 | Event pulses, one bit per source |
| bus_addr | input | 2 | Register select: 0 status, 1 mask |
| bus_lane | input | 2 | Byte lane within the register |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data byte |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is an event that lands on a bit in the very cycle its clear is applied. That case is separate from an event that lands between the snapshot and the clear. The bench reaches it with a combined task that raises the event strobe and the lane-3 read strobe in the same cycle, after a lane-0 read has armed the snapshot. In a separate task, the bench raises a different event between the two reads and then watches `irq_n` cycle by cycle. The line must stay high for two cycles and then fall again.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] SEL_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] SEL_MASK   = 2'd1;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int NUM_BYTES = 4,
  localparam int W = NUM_BYTES * 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         snap_take,
  input  logic         clr_req,
  output logic [W-1:0] status,
  output logic         armed,
  output logic         clr_fire
);
  logic [W-1:0] snap;
  logic [W-1:0] clr_vec;

  always_comb begin
    clr_fire = clr_req & armed;
    clr_vec  = clr_fire ? snap : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      snap   <= '0;
      armed  <= 1'b0;
    end else begin
      status <= (status & ~clr_vec) | evt;
      if (snap_take) begin
        snap  <= status;
        armed <= 1'b1;
      end else if (clr_req) begin
        armed <= 1'b0;
      end
    end
  end

  // R2 / R7: an event bit is always set after the edge, clear or not
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((status & $past(evt)) == $past(evt)));

  // R4: snapshot bits with no coincident event are gone after a clear
  p_clear_snap_r4: assert property (@(posedge clk) disable iff (rst)
    clr_fire |=> ((status & $past(snap) & ~$past(evt)) == '0));

  // R5: bits outside the snapshot survive a clear
  p_keep_new_r5: assert property (@(posedge clk) disable iff (rst)
    clr_fire |=> ((status & $past(status & ~snap)) == $past(status & ~snap)));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NUM_BYTES = 4,
  localparam int W = NUM_BYTES * 8,
  localparam int LANE_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [LANE_W-1:0] lane,
  input  logic [7:0]        wr_data,
  output logic [W-1:0]      mask
);
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        mask[g*8 +: 8] <= 8'h00;
      else if (wr_en && lane == LANE_W'(g))
        mask[g*8 +: 8] <= wr_data;
    end
  end
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
  parameter int QUIET = 2,
  localparam int CW = $clog2(QUIET + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic pend,
  input  logic clr_fire,
  output logic irq_n
);
  logic [CW-1:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_cnt <= '0;
      irq_n     <= 1'b1;
    end else if (clr_fire) begin
      quiet_cnt <= CW'(QUIET - 1);
      irq_n     <= 1'b1;
    end else if (quiet_cnt != '0) begin
      quiet_cnt <= quiet_cnt - 1'b1;
      irq_n     <= 1'b1;
    end else begin
      irq_n     <= ~pend;
    end
  end

  // R9: line inactive in the cycle after a clear
  p_quiet_first_r9: assert property (@(posedge clk) disable iff (rst)
    clr_fire |=> irq_n);

  if (QUIET >= 2) begin : g_quiet2
    // R9: and still inactive one cycle later
    p_quiet_second_r9: assert property (@(posedge clk) disable iff (rst)
      clr_fire |=> ##1 irq_n);
  end

  // R8: pending request outside the window drives the line low
  p_assert_r8: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr_fire && quiet_cnt == '0) |=> !irq_n);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int NUM_BYTES = 4,
  parameter int QUIET = 2,
  localparam int W = NUM_BYTES * 8,
  localparam int LANE_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      evt,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LANE_W-1:0] bus_lane,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              irq_n
);
  logic [W-1:0] status;
  logic [W-1:0] mask;
  logic         armed;
  logic         clr_fire;
  logic         rd_status;
  logic         snap_take;
  logic         clr_req;
  logic         mask_wr;
  logic         pend;
  logic [7:0]   rd_next;

  always_comb begin
    rd_status = bus_rd && (bus_addr == SEL_STATUS);
    snap_take = rd_status && (bus_lane == '0);
    clr_req   = rd_status && (bus_lane == LANE_W'(NUM_BYTES - 1));
    mask_wr   = bus_wr && (bus_addr == SEL_MASK);
    pend      = |(status & mask);
  end

  irq_status_reg #(.NUM_BYTES(NUM_BYTES)) u_status (
    .clk(clk), .rst(rst), .evt(evt),
    .snap_take(snap_take), .clr_req(clr_req),
    .status(status), .armed(armed), .clr_fire(clr_fire)
  );

  irq_mask_reg #(.NUM_BYTES(NUM_BYTES)) u_mask (
    .clk(clk), .rst(rst), .wr_en(mask_wr), .lane(bus_lane),
    .wr_data(wr_data), .mask(mask)
  );

  irq_out_gen #(.QUIET(QUIET)) u_out (
    .clk(clk), .rst(rst), .pend(pend), .clr_fire(clr_fire), .irq_n(irq_n)
  );

  always_comb begin
    rd_next = 8'h00;
    if (bus_addr == SEL_STATUS)
      rd_next = status[int'(bus_lane)*8 +: 8];
    else if (bus_addr == SEL_MASK)
      rd_next = mask[int'(bus_lane)*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= 8'h00;
    else if (bus_rd)
      rd_data <= rd_next;
  end

  // R6: a last-lane read with no armed snapshot removes no bit
  p_unarmed_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !armed) |=> ((status & $past(status)) == $past(status)));

  // R11 / R8: the line can only be low if a masked bit was pending
  p_gate_r11: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past(pend));

  // R10: mask changes only through a mask write
  p_mask_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(mask_wr) |-> $stable(mask));
endmodule

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] evt = '0;
  logic [1:0]  bus_addr = '0;
  logic [1:0]  bus_lane = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        irq_n;

  int checks = 0;
  int fails  = 0;

  irq_status_unit u_irq_status_unit (
    .clk(clk), .rst(rst), .evt(evt), .bus_addr(bus_addr), .bus_lane(bus_lane),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .wr_data(wr_data),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic [1:0] l);
    bus_addr = a; bus_lane = l; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] l, input logic [7:0] d);
    bus_addr = a; bus_lane = l; wr_data = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] v);
    evt = v;
    tick();
    evt = '0;
  endtask

  task automatic clear_all();
    rd(2'd0, 2'd0);
    rd(2'd0, 2'd3);
    tick(); tick();
  endtask

  task automatic t_reset();
    check("R1 irq_n", irq_n, 1);
    check("R1 rd_data", rd_data, 0);
    rd(2'd1, 2'd2); check("R1 mask", rd_data, 0);
    rd(2'd0, 2'd1); check("R1 status", rd_data, 0);
  endtask

  task automatic t_masked_off();
    pulse(32'h0000_0101);
    tick();
    check("R11 irq_n stays high", irq_n, 1);
    rd(2'd0, 2'd1); check("R2 status lane1", rd_data, 8'h01);
    clear_all();
  endtask

  task automatic t_lanes();
    pulse(32'h8040_2010);
    pulse(32'h0000_0002);
    rd(2'd0, 2'd0); check("R3 lane0", rd_data, 8'h12);
    rd(2'd0, 2'd1); check("R3 lane1", rd_data, 8'h20);
    rd(2'd0, 2'd2); check("R3 lane2", rd_data, 8'h40);
    rd(2'd0, 2'd3); check("R3 lane3", rd_data, 8'h80);
    rd(2'd0, 2'd2); check("R4 cleared lane2", rd_data, 8'h00);
    rd(2'd0, 2'd0); check("R4 cleared lane0", rd_data, 8'h00);
    rd(2'd2, 2'd0); check("R3 unused address", rd_data, 8'h00);
    rd(2'd0, 2'd3);
  endtask

  task automatic t_mask();
    wr(2'd1, 2'd2, 8'hA5);
    wr(2'd0, 2'd0, 8'hFF);
    rd(2'd1, 2'd2); check("R10 mask lane2", rd_data, 8'hA5);
    rd(2'd1, 2'd0); check("R10 status write ignored", rd_data, 8'h00);
    rd(2'd0, 2'd0); check("R10 status unchanged", rd_data, 8'h00);
    rd(2'd0, 2'd3);
    wr(2'd1, 2'd2, 8'h01);
    pulse(32'h0002_0000); tick();
    check("R8 unmasked bit idle", irq_n, 1);
    pulse(32'h0001_0000);
    check("R8 one cycle latency", irq_n, 1);
    tick();
    check("R8 asserted", irq_n, 0);
    clear_all();
    check("R8 released after clear", irq_n, 1);
  endtask

  task automatic t_snapshot();
    for (int l = 0; l < 4; l++) wr(2'd1, l[1:0], 8'hFF);
    pulse(32'h0000_0001); tick();
    check("R8 pending", irq_n, 0);
    rd(2'd0, 2'd0);
    pulse(32'h0000_0200);
    rd(2'd0, 2'd3);
    check("R9 quiet cycle 1", irq_n, 1);
    tick();
    check("R9 quiet cycle 2", irq_n, 1);
    tick();
    check("R9 reasserts after window", irq_n, 0);
    rd(2'd0, 2'd0); check("R4 bit0 cleared", rd_data, 8'h00);
    rd(2'd0, 2'd1); check("R5 late bit kept", rd_data, 8'h02);
  endtask

  task automatic t_set_wins();
    bus_addr = 2'd0; bus_lane = 2'd3; bus_rd = 1'b1; evt = 32'h0000_0200;
    tick();
    bus_rd = 1'b0; evt = '0;
    rd(2'd0, 2'd1); check("R7 set beats clear", rd_data, 8'h02);
  endtask

  task automatic t_unarmed();
    rd(2'd0, 2'd3);
    rd(2'd0, 2'd1); check("R6 unarmed clear ignored", rd_data, 8'h02);
    tick(); tick();
    check("R6 irq still pending", irq_n, 0);
    clear_all();
    rd(2'd0, 2'd1); check("R4 final clear", rd_data, 8'h00);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_masked_off();
    t_lanes();
    t_mask();
    t_snapshot();
    t_set_wins();
    t_unarmed();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule